// File: doc/BRIEF.md
# Thermal Limit Alert Controller

This block watches a stream of signed 9-bit temperature samples in half-degree steps. Each sample arrives with a one-cycle conversion strobe. The block compares each sample with two programmable thresholds: an upper trip limit and a lower release (hysteresis) limit. The result drives two outputs. The first is a sticky alert status bit, which drives an active-low request line. The second is a separate over-temperature pin with selectable polarity. A small register port lets software program the thresholds and the mode bits, read back the latest sample, and read the status. Reading the status clears it.

All decisions come from one two-state tracking machine. Its states are `TRK_COOL` and `TRK_HOT`. It moves only when a conversion is accepted:
- `TRK_COOL` to `TRK_HOT` when the sample is above the trip limit. This is the *rise* transition.
- `TRK_HOT` to `TRK_COOL` when the sample is below the release limit. This is the *fall* transition.
- `TRK_HOT` to `TRK_HOT` on any other accepted sample. This is the *hold* transition.

The chosen mode decides which transitions raise an event. Comparator alert mode raises events on rise and hold. Interrupt alert mode raises events on rise and fall.

Top module: `thermal_alert_ctl`

Register map. Addresses are on `reg_addr` and the data is 8 bits wide. A 9-bit value is split into a high byte that carries bits 8..1 and a low byte whose bit 7 carries bit 0.
- 0: sample, high byte (read-only)
- 1: sample, low byte (read-only)
- 2: trip limit, high byte
- 3: trip limit, low byte
- 4: release limit, high byte
- 5: release limit, low byte
- 6: control
- 7: status (read-only, read clears)

Control bits:
- bit0: halt
- bit1: pin interrupt mode
- bit2: pin active-high
- bit3: alert interrupt mode
- bit4: alert mask

## Requirements
- R1: After reset the trip limit reads 50h/00h (80 °C), the release limit reads 4Bh/00h (75 °C), and control and status read 00h. `irq_n` is 1. `ovt_pin` is 1, because the pin defaults to active-low.
- R2: An accepted conversion stores the sample. Address 0 returns sample bits 8..1. Address 1 returns sample bit 0 in bit 7, with all other bits 0.
- R3: In comparator alert mode (control bit3 = 0), a conversion whose sample is above the trip limit sets status bit0. `irq_n` goes low from the edge that accepts that conversion.
- R4: Reading address 7 returns status in bit0 and clears it at that edge. If a conversion sets status at the same edge, the set wins.
- R5: In comparator alert mode, each conversion in `TRK_HOT` that is not below the release limit sets status again. A conversion below the release limit returns to `TRK_COOL` and does not set status.
- R6: In interrupt alert mode (control bit3 = 1), the rise transition sets status once. Further hold conversions do not set status. The fall transition sets status.
- R7: A release limit of exactly 127.0 °C (high byte 7Fh, low bit 0) forces comparator alert behaviour, whatever the value of control bit3.
- R8: In pin comparator mode (control bit1 = 0), the pin is active from the conversion that exceeds the trip limit until a conversion below the release limit.
- R9: In pin interrupt mode (control bit1 = 1), a rise or fall transition activates the pin. It stays active until status is read.
- R10: Control bit2 = 1 makes the pin active-high. Control bit2 = 0 makes it active-low.
- R11: While control bit0 (halt) is 1, conversions are ignored: the stored sample and the tracking state do not change. Status is frozen, including against status reads.
- R12: Control bit4 (mask) holds `irq_n` at 1, but status still latches. Clearing the mask exposes status that is already latched.
- R13: All comparisons are signed two's complement. A sample of +5 °C against a trip limit of −10 °C counts as above the limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_valid | input | 1 | One-cycle strobe: a new sample is on `conv_temp` |
| conv_temp | input | 9 | Signed sample in half-degree steps |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (needed for clear-on-read) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from `reg_addr` |
| irq_n | output | 1 | Active-low alert request |
| ovt_pin | output | 1 | Over-temperature pin, polarity set by control bit2 |

## Verification
The assertions assume that `rst_n` is held low for at least one clock edge. They also assume that `conv_valid` and `reg_rd` are single-cycle strobes sampled at the rising edge. The pin assertion additionally requires that no register write occurs in the same cycle as the conversion it checks. The stimulus satisfies all of these:
- Every strobe and write is driven at the falling edge and lasts exactly one cycle.
- Control writes never coincide with a conversion.
- The only deliberate overlap is one conversion issued together with a status read, which checks the set-over-clear priority.

// File: rtl/thermal_pkg.sv
package thermal_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [0:0] {
        TRK_COOL = 1'b0,
        TRK_HOT  = 1'b1
    } trk_state_e;

    typedef struct packed {
        logic rise;
        logic hold;
        logic fall;
    } trk_evt_t;

    localparam logic [ADDR_W-1:0] A_SMP_HI  = 3'd0;
    localparam logic [ADDR_W-1:0] A_SMP_LO  = 3'd1;
    localparam logic [ADDR_W-1:0] A_TRIP_HI = 3'd2;
    localparam logic [ADDR_W-1:0] A_TRIP_LO = 3'd3;
    localparam logic [ADDR_W-1:0] A_REL_HI  = 3'd4;
    localparam logic [ADDR_W-1:0] A_REL_LO  = 3'd5;
    localparam logic [ADDR_W-1:0] A_CTRL    = 3'd6;
    localparam logic [ADDR_W-1:0] A_STAT    = 3'd7;

    localparam int C_HALT     = 0;
    localparam int C_PIN_IRQ  = 1;
    localparam int C_PIN_HIGH = 2;
    localparam int C_ALR_IRQ  = 3;
    localparam int C_ALR_MASK = 4;

endpackage

// File: rtl/thermal_regs.sv
module thermal_regs
    import thermal_pkg::*;
#(
    parameter int                DATA_W      = 8,
    parameter logic [DATA_W-1:0] TRIP_RST_HI = 8'h50,
    parameter logic [DATA_W-1:0] REL_RST_HI  = 8'h4B,
    localparam int               TW          = DATA_W + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic                 reg_rd,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    input  logic                 conv_take,
    input  logic [TW-1:0]        conv_temp,
    input  logic                 alert_status,
    output logic signed [TW-1:0] trip_lim,
    output logic signed [TW-1:0] rel_lim,
    output logic [DATA_W-1:0]    ctrl,
    output logic                 stat_rd
);

    logic [TW-1:0]     sample_q;
    logic [TW-1:0]     trip_q;
    logic [TW-1:0]     rel_q;
    logic [DATA_W-1:0] ctrl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sample_q <= '0;
            trip_q   <= {TRIP_RST_HI, 1'b0};
            rel_q    <= {REL_RST_HI, 1'b0};
            ctrl_q   <= '0;
        end else begin
            if (conv_take) begin
                sample_q <= conv_temp;
            end
            if (reg_wr) begin
                case (reg_addr)
                    A_TRIP_HI: trip_q[TW-1:1] <= reg_wdata;
                    A_TRIP_LO: trip_q[0]      <= reg_wdata[DATA_W-1];
                    A_REL_HI:  rel_q[TW-1:1]  <= reg_wdata;
                    A_REL_LO:  rel_q[0]       <= reg_wdata[DATA_W-1];
                    A_CTRL:    ctrl_q         <= reg_wdata;
                    default:   ;
                endcase
            end
        end
    end

    always_comb begin
        case (reg_addr)
            A_SMP_HI:  reg_rdata = sample_q[TW-1:1];
            A_SMP_LO:  reg_rdata = {sample_q[0], {(DATA_W-1){1'b0}}};
            A_TRIP_HI: reg_rdata = trip_q[TW-1:1];
            A_TRIP_LO: reg_rdata = {trip_q[0], {(DATA_W-1){1'b0}}};
            A_REL_HI:  reg_rdata = rel_q[TW-1:1];
            A_REL_LO:  reg_rdata = {rel_q[0], {(DATA_W-1){1'b0}}};
            A_CTRL:    reg_rdata = ctrl_q;
            A_STAT:    reg_rdata = {{(DATA_W-1){1'b0}}, alert_status};
            default:   reg_rdata = '0;
        endcase
    end

    assign trip_lim = $signed(trip_q);
    assign rel_lim  = $signed(rel_q);
    assign ctrl     = ctrl_q;
    assign stat_rd  = reg_rd && (reg_addr == A_STAT) && !ctrl_q[C_HALT];

    // R11: while halted, the stored sample does not move
    a_r11_sample_frozen : assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[C_HALT] |=> $stable(sample_q));

endmodule

// File: rtl/thermal_track.sv
module thermal_track
    import thermal_pkg::*;
#(
    parameter int TW = 9
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 conv_take,
    input  logic signed [TW-1:0] temp,
    input  logic signed [TW-1:0] trip_lim,
    input  logic signed [TW-1:0] rel_lim,
    output trk_state_e           state,
    output trk_evt_t             evt
);

    trk_state_e state_q;
    trk_state_e state_d;
    logic       above_trip;
    logic       below_rel;

    assign above_trip = temp > trip_lim;
    assign below_rel  = temp < rel_lim;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TRK_COOL;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (conv_take) begin
            unique case (state_q)
                TRK_COOL: if (above_trip) state_d = TRK_HOT;
                TRK_HOT:  if (below_rel)  state_d = TRK_COOL;
                default:  state_d = TRK_COOL;
            endcase
        end
    end

    always_comb begin
        evt = '0;
        if (conv_take) begin
            unique case (state_q)
                TRK_COOL: evt.rise = above_trip;
                TRK_HOT: begin
                    evt.fall = below_rel;
                    evt.hold = !below_rel;
                end
                default: evt = '0;
            endcase
        end
    end

    assign state = state_q;

    // R5/R11: the tracking state only moves on an accepted conversion
    a_r5_move_needs_conv : assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != $past(state_q)) |-> $past(conv_take));

endmodule

// File: rtl/thermal_alert_out.sv
module thermal_alert_out
    import thermal_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  trk_evt_t   evt,
    input  trk_state_e state,
    input  logic       alr_irq_mode,
    input  logic       force_cmp,
    input  logic       alr_mask,
    input  logic       pin_irq_mode,
    input  logic       pin_high,
    input  logic       stat_rd,
    output logic       alert_status,
    output logic       irq_n,
    output logic       ovt_pin
);

    logic status_q;
    logic pin_lat_q;
    logic alr_irq_eff;
    logic alr_set;
    logic pin_set;
    logic pin_act;

    assign alr_irq_eff = alr_irq_mode && !force_cmp;
    assign alr_set     = evt.rise || (alr_irq_eff ? evt.fall : evt.hold);
    assign pin_set     = pin_irq_mode && (evt.rise || evt.fall);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q  <= 1'b0;
            pin_lat_q <= 1'b0;
        end else begin
            if (alr_set) begin
                status_q <= 1'b1;
            end else if (stat_rd) begin
                status_q <= 1'b0;
            end
            if (pin_set) begin
                pin_lat_q <= 1'b1;
            end else if (stat_rd) begin
                pin_lat_q <= 1'b0;
            end
        end
    end

    always_comb begin
        pin_act      = pin_irq_mode ? pin_lat_q : (state == TRK_HOT);
        ovt_pin      = pin_high ? pin_act : !pin_act;
        irq_n        = !(status_q && !alr_mask);
        alert_status = status_q;
    end

    // R4: a status read with no event at that edge leaves status clear
    a_r4_read_clears : assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !evt.rise && !evt.hold && !evt.fall) |=> !status_q);

    // R3/R6: a rise transition always latches status
    a_r3_rise_sets : assert property (@(posedge clk) disable iff (!rst_n)
        evt.rise |=> status_q);

endmodule

// File: rtl/thermal_alert_ctl.sv
module thermal_alert_ctl
    import thermal_pkg::*;
#(
    parameter int                DATA_W      = 8,
    parameter logic [DATA_W-1:0] TRIP_RST_HI = 8'h50,
    parameter logic [DATA_W-1:0] REL_RST_HI  = 8'h4B,
    parameter logic [DATA_W-1:0] FORCE_HI    = 8'h7F,
    localparam int               TW          = DATA_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_valid,
    input  logic [TW-1:0]     conv_temp,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_n,
    output logic              ovt_pin
);

    localparam logic signed [TW-1:0] FORCE_REL = {FORCE_HI, 1'b0};

    logic signed [TW-1:0] trip_lim;
    logic signed [TW-1:0] rel_lim;
    logic [DATA_W-1:0]    ctrl;
    logic                 stat_rd;
    logic                 conv_take;
    logic                 alert_status;
    logic                 force_cmp;
    trk_state_e           state;
    trk_evt_t             evt;

    assign conv_take = conv_valid && !ctrl[C_HALT];
    assign force_cmp = (rel_lim == FORCE_REL);

    thermal_regs #(
        .DATA_W      (DATA_W),
        .TRIP_RST_HI (TRIP_RST_HI),
        .REL_RST_HI  (REL_RST_HI)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_wr       (reg_wr),
        .reg_rd       (reg_rd),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .conv_take    (conv_take),
        .conv_temp    (conv_temp),
        .alert_status (alert_status),
        .trip_lim     (trip_lim),
        .rel_lim      (rel_lim),
        .ctrl         (ctrl),
        .stat_rd      (stat_rd)
    );

    thermal_track #(
        .TW (TW)
    ) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .conv_take (conv_take),
        .temp      ($signed(conv_temp)),
        .trip_lim  (trip_lim),
        .rel_lim   (rel_lim),
        .state     (state),
        .evt       (evt)
    );

    thermal_alert_out u_out (
        .clk          (clk),
        .rst_n        (rst_n),
        .evt          (evt),
        .state        (state),
        .alr_irq_mode (ctrl[C_ALR_IRQ]),
        .force_cmp    (force_cmp),
        .alr_mask     (ctrl[C_ALR_MASK]),
        .pin_irq_mode (ctrl[C_PIN_IRQ]),
        .pin_high     (ctrl[C_PIN_HIGH]),
        .stat_rd      (stat_rd),
        .alert_status (alert_status),
        .irq_n        (irq_n),
        .ovt_pin      (ovt_pin)
    );

    // R11: halt freezes the alert status, even against status reads
    a_r11_status_frozen : assert property (@(posedge clk) disable iff (!rst_n)
        ctrl[C_HALT] |=> $stable(alert_status));

    // R8: in pin comparator mode, exceeding the trip limit activates the pin
    a_r8_pin_follows_trip : assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl[C_PIN_IRQ] && conv_take && !reg_wr && ($signed(conv_temp) > trip_lim))
        |=> (ovt_pin == ctrl[C_PIN_HIGH]));

endmodule

// File: tb/thermal_alert_ctl_tb.sv
`timescale 1ns/1ps
module thermal_alert_ctl_tb;

    typedef struct packed {
        logic [8:0] temp;
        logic       rd_after;
        logic       exp_irq_n;
        logic       exp_pin;
    } vec_t;

    // comparator mode, active-low pin, trip 160 (80.0 C), release 150 (75.0 C)
    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{9'd100, 1'b0, 1'b1, 1'b1},
        '{9'd160, 1'b0, 1'b1, 1'b1},
        '{9'd161, 1'b1, 1'b0, 1'b0},
        '{9'd155, 1'b1, 1'b0, 1'b0},
        '{9'd150, 1'b1, 1'b0, 1'b0},
        '{9'd149, 1'b0, 1'b1, 1'b1},
        '{9'd155, 1'b0, 1'b1, 1'b1},
        '{9'd200, 1'b0, 1'b0, 1'b0},
        '{9'd100, 1'b1, 1'b0, 1'b1},
        '{9'd100, 1'b0, 1'b1, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       conv_valid = 1'b0;
    logic [8:0] conv_temp = '0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq_n;
    logic       ovt_pin;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    thermal_alert_ctl u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .conv_valid (conv_valid),
        .conv_temp  (conv_temp),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .irq_n      (irq_n),
        .ovt_pin    (ovt_pin)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic conv(input logic [8:0] t);
        @(negedge clk);
        conv_valid = 1'b1;
        conv_temp  = t;
        @(negedge clk);
        conv_valid = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_rd   = 1'b1;
        reg_addr = a;
        #1;
        d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] v);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_addr  = a;
        reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    initial begin
        #400000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog (all requirements) actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq_n", irq_n, 1);
        chk("R1 ovt_pin", ovt_pin, 1);
        rd(3'd2, d); chk("R1 trip hi", d, 8'h50);
        rd(3'd3, d); chk("R1 trip lo", d, 8'h00);
        rd(3'd4, d); chk("R1 rel hi", d, 8'h4B);
        rd(3'd5, d); chk("R1 rel lo", d, 8'h00);
        rd(3'd6, d); chk("R1 ctrl", d, 8'h00);
        rd(3'd7, d); chk("R1 status", d, 8'h00);

        // R3/R4/R5/R8 vector table
        for (int i = 0; i < NV; i++) begin
            conv(VECS[i].temp);
            chk("R3/R5 irq_n", irq_n, VECS[i].exp_irq_n);
            chk("R8 ovt_pin", ovt_pin, VECS[i].exp_pin);
            if (VECS[i].rd_after) begin
                rd(3'd7, d);
                chk("R4 status read", d, {7'd0, !VECS[i].exp_irq_n});
            end
        end

        // R2 sample storage
        conv(9'h033);
        rd(3'd0, d); chk("R2 sample hi", d, 8'h19);
        rd(3'd1, d); chk("R2 sample lo", d, 8'h80);

        // R6 interrupt alert mode
        wr(3'd6, 8'h08);
        conv(9'd170); chk("R6 rise", irq_n, 0);
        rd(3'd7, d);  chk("R6 status", d, 1);
        conv(9'd170); chk("R6 no hold event", irq_n, 1);
        conv(9'd140); chk("R6 fall event", irq_n, 0);
        rd(3'd7, d);
        conv(9'd140); chk("R6 idle cool", irq_n, 1);

        // R9/R10 pin interrupt mode, active-high
        wr(3'd6, 8'h0E);
        chk("R10 idle high-pol", ovt_pin, 0);
        conv(9'd170); chk("R9 rise pin", ovt_pin, 1);
        rd(3'd7, d);  chk("R9 read clears pin", ovt_pin, 0);
        conv(9'd170); chk("R9 hold no pin", ovt_pin, 0);
        conv(9'd140); chk("R9 fall pin", ovt_pin, 1);
        rd(3'd7, d);  chk("R9 read clears pin", ovt_pin, 0);

        // R10 comparator pin, active-high
        wr(3'd6, 8'h04);
        conv(9'd170); chk("R10 hot high", ovt_pin, 1);
        conv(9'd140); chk("R10 cool high", ovt_pin, 0);
        rd(3'd7, d);

        // R7 release at 127.0 C forces comparator
        wr(3'd6, 8'h08);
        wr(3'd4, 8'h7F);
        wr(3'd5, 8'h00);
        conv(9'h0FF); chk("R7 rise", irq_n, 0);
        rd(3'd7, d);  chk("R7 cleared", irq_n, 1);
        conv(9'h0FF); chk("R7 hold sets", irq_n, 0);
        rd(3'd7, d);
        conv(9'd100); chk("R7 fall silent", irq_n, 1);
        wr(3'd4, 8'h4B);
        wr(3'd6, 8'h00);

        // R13 signed compare: trip -10 C, release -15 C
        wr(3'd2, 8'hF6);
        wr(3'd4, 8'hF1);
        conv(9'h00A); chk("R13 +5C above -10C", irq_n, 0);
        chk("R13 pin hot", ovt_pin, 0);
        rd(3'd7, d);
        conv(9'h1D8); chk("R13 -20C below rel", irq_n, 1);
        chk("R13 pin cool", ovt_pin, 1);
        wr(3'd2, 8'h50);
        wr(3'd4, 8'h4B);

        // R11 halt
        conv(9'd200); chk("R11 pre set", irq_n, 0);
        wr(3'd6, 8'h01);
        rd(3'd7, d);  chk("R11 status read while halted", d, 1);
        chk("R11 status frozen", irq_n, 0);
        conv(9'd100);
        rd(3'd0, d);  chk("R11 sample frozen", d, 8'h64);
        wr(3'd6, 8'h00);
        chk("R11 status kept", irq_n, 0);
        rd(3'd7, d);  chk("R11 read after halt", irq_n, 1);

        // R12 mask (state is still hot)
        wr(3'd6, 8'h10);
        conv(9'd200); chk("R12 masked", irq_n, 1);
        wr(3'd6, 8'h00); chk("R12 latched exposed", irq_n, 0);
        rd(3'd7, d);  chk("R12 status", d, 1);

        // R4 set wins over clear in the same cycle
        @(negedge clk);
        conv_valid = 1'b1; conv_temp = 9'd200;
        reg_rd = 1'b1; reg_addr = 3'd7;
        @(negedge clk);
        conv_valid = 1'b0; reg_rd = 1'b0;
        chk("R4 set beats clear", irq_n, 0);
        rd(3'd7, d); chk("R4 final read", irq_n, 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule